// File: doc/BRIEF.md
# Static LCD Segment and Backplane Driver

This block turns a held three-and-a-half digit decimal reading into static LCD drive waveforms. A divided-down square wave serves as the common backplane. Every segment output is a copy of that square wave: in phase with it when the segment is dark, and inverted when the segment is lit. The voltage across every segment therefore averages to zero.

The reading arrives as three BCD digits, a flag for the leading "1", a sign flag, an overrange flag and a lamp-test request. All of these inputs are sampled only on the clock edge where the backplane toggles. Segment outputs and backplane come from registers that load on that same edge, so the two can never skew against each other. Overrange blanks the three full digits. Lamp test lights every segment and takes priority over overrange.

Top module: `lcd_static_drv`

## Requirements
- R1: While `rst` is high and after its release, `bp`, `seg_digits`, `seg_half` and `seg_minus` are all 0, and they stay 0 until the first backplane toggle.
- R2: `bp` toggles exactly every HALF_PERIOD clocks (default 400), so its period is 2*HALF_PERIOD (default 800) clocks with a 50% duty cycle. The first toggle falls on the HALF_PERIOD-th rising edge after reset is released.
- R3: Segment outputs change only on an edge where `bp` toggles. A lit segment then equals the inverse of `bp`, and a dark segment equals `bp`.
- R4: Inputs are sampled only at the toggle edge. A change made between toggles does not show on any output until the next toggle.
- R5: Digit i uses `digits_bcd[4i+3:4i]` (digit 0 is least significant) and drives `seg_digits[7i+6:7i]`, with bit 0 = segment a through bit 6 = segment g. Lit-segment codes for 0..9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).
- R6: A BCD code from 10 to 15 leaves all seven segments of that digit dark.
- R7: Both bits of `seg_half` (segments b and c of the leading digit) are lit when `lead_one` is 1, and both are dark otherwise.
- R8: `seg_minus` is lit when `negative` is 1, and dark otherwise.
- R9: With `overrange` high, all full-digit segments are dark, while `seg_half` and `seg_minus` still follow R7 and R8.
- R10: With `lamp_test` high, every segment output is lit (the display reads 1888 with the minus sign). This holds regardless of `overrange` and of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_bcd | input | 12 | Three BCD digits, least significant in bits 3:0 |
| lead_one | input | 1 | Leading half digit shows "1" |
| negative | input | 1 | Reading is negative |
| overrange | input | 1 | Blank the three full digits |
| lamp_test | input | 1 | Light every segment |
| bp | output | 1 | Backplane square wave |
| seg_digits | output | 21 | Segment drives of the full digits, 7 per digit, a in bit 0 |
| seg_half | output | 2 | Segments b (bit 0) and c (bit 1) of the leading digit |
| seg_minus | output | 1 | Minus sign segment drive |

## Verification
If the divider count is wrong, the backplane period at the pins changes, and this shows on the very next toggle, at most 400 clocks later. A wrong decode or a wrong priority between blanking and lamp test gives a segment with the wrong phase relative to `bp` on the first toggle after the stimulus. A segment register loaded on the wrong edge shows up as a segment that moves while `bp` stays still, or as an input change that appears mid-phase. The bench therefore samples once per half period, and also at mid-phase.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

  localparam int SEGS_PER_DIGIT = 7;

  typedef logic [SEGS_PER_DIGIT-1:0] seg7_t;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g
  function automatic seg7_t bcd_to_seg7(input logic [3:0] code);
    seg7_t s;
    case (code)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider #(
  parameter int HALF_PERIOD = 400
) (
  input  logic clk,
  input  logic rst,
  output logic bp,
  output logic toggle
);
  localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign toggle = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      bp    <= 1'b0;
    end else if (toggle) begin
      cnt_q <= '0;
      bp    <= ~bp;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_digit_decoder.sv
module lcd_digit_decoder
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS = 3
) (
  input  logic [NUM_DIGITS*4-1:0]              bcd,
  output logic [NUM_DIGITS*SEGS_PER_DIGIT-1:0] lit
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
    assign lit[i*SEGS_PER_DIGIT +: SEGS_PER_DIGIT] = bcd_to_seg7(bcd[i*4 +: 4]);
  end
endmodule

// File: rtl/lcd_lit_select.sv
module lcd_lit_select #(
  parameter int DIG_SEGS = 21
) (
  input  logic [DIG_SEGS-1:0] dec_lit,
  input  logic                lead_one,
  input  logic                negative,
  input  logic                overrange,
  input  logic                lamp_test,
  output logic [DIG_SEGS-1:0] dig_on,
  output logic [1:0]          half_on,
  output logic                minus_on
);
  always_comb begin
    if (lamp_test) begin
      dig_on   = '1;
      half_on  = 2'b11;
      minus_on = 1'b1;
    end else begin
      dig_on   = overrange ? '0 : dec_lit;
      half_on  = {2{lead_one}};
      minus_on = negative;
    end
  end
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS  = 3,
  parameter int HALF_PERIOD = 400
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_DIGITS*4-1:0]           digits_bcd,
  input  logic                              lead_one,
  input  logic                              negative,
  input  logic                              overrange,
  input  logic                              lamp_test,
  output logic                              bp,
  output logic [NUM_DIGITS*SEGS_PER_DIGIT-1:0] seg_digits,
  output logic [1:0]                        seg_half,
  output logic                              seg_minus
);
  localparam int DIG_SEGS = NUM_DIGITS * SEGS_PER_DIGIT;

  logic                bp_int;
  logic                toggle;
  logic [DIG_SEGS-1:0] dec_lit;
  logic [DIG_SEGS-1:0] dig_on;
  logic [1:0]          half_on;
  logic                minus_on;
  logic                bp_next;

  lcd_bp_divider #(.HALF_PERIOD(HALF_PERIOD)) u_div (
    .clk    (clk),
    .rst    (rst),
    .bp     (bp_int),
    .toggle (toggle)
  );

  lcd_digit_decoder #(.NUM_DIGITS(NUM_DIGITS)) u_dec (
    .bcd (digits_bcd),
    .lit (dec_lit)
  );

  lcd_lit_select #(.DIG_SEGS(DIG_SEGS)) u_sel (
    .dec_lit   (dec_lit),
    .lead_one  (lead_one),
    .negative  (negative),
    .overrange (overrange),
    .lamp_test (lamp_test),
    .dig_on    (dig_on),
    .half_on   (half_on),
    .minus_on  (minus_on)
  );

  assign bp_next = ~bp_int;
  assign bp      = bp_int;

  // Segments load on the same edge the backplane toggles
  always_ff @(posedge clk) begin
    if (rst) begin
      seg_digits <= '0;
      seg_half   <= '0;
      seg_minus  <= 1'b0;
    end else if (toggle) begin
      seg_digits <= dig_on ^ {DIG_SEGS{bp_next}};
      seg_half   <= half_on ^ {2{bp_next}};
      seg_minus  <= minus_on ^ bp_next;
    end
  end
endmodule

// File: rtl/lcd_static_drv_chk.sv
module lcd_static_drv_chk #(
  parameter int NUM_DIGITS  = 3,
  parameter int HALF_PERIOD = 400
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       lead_one,
  input logic                       negative,
  input logic                       overrange,
  input logic                       lamp_test,
  input logic                       bp,
  input logic [NUM_DIGITS*7-1:0]    seg_digits,
  input logic [1:0]                 seg_half,
  input logic                       seg_minus
);
  localparam int W  = NUM_DIGITS * 7;
  localparam int CW = $clog2(HALF_PERIOD + 1) + 1;

  logic          bp_q;
  logic [CW-1:0] run_q;
  logic          chg;

  assign chg = (bp != bp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bp_q  <= 1'b0;
      run_q <= '0;
    end else begin
      bp_q  <= bp;
      run_q <= chg ? CW'(1) : run_q + 1'b1;
    end
  end

  // R2: toggle spacing
  p_bp_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    chg |-> run_q == CW'(HALF_PERIOD));
  p_bp_not_late_r2: assert property (@(posedge clk) disable iff (rst)
    run_q <= CW'(HALF_PERIOD));
  // R3: segments move only with the backplane
  p_seg_with_bp_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable({seg_digits, seg_half, seg_minus}) |-> !$stable(bp));
  // R10: lamp test lights everything
  p_lamp_all_r10: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bp) && $past(lamp_test)) |->
      (seg_digits == {W{~bp}} && seg_half == {2{~bp}} && seg_minus == ~bp));
  // R9: overrange blanks full digits
  p_over_blank_r9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(bp) && $past(overrange) && !$past(lamp_test)) |->
      seg_digits == {W{bp}});
  // R8: minus sign follows the sign flag
  p_minus_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> seg_minus == (($past(negative) || $past(lamp_test)) ^ bp));
  // R7: leading one
  p_half_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(bp) |-> seg_half == {2{($past(lead_one) || $past(lamp_test)) ^ bp}});
endmodule

bind lcd_static_drv lcd_static_drv_chk #(
  .NUM_DIGITS  (NUM_DIGITS),
  .HALF_PERIOD (HALF_PERIOD)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lead_one   (lead_one),
  .negative   (negative),
  .overrange  (overrange),
  .lamp_test  (lamp_test),
  .bp         (bp),
  .seg_digits (seg_digits),
  .seg_half   (seg_half),
  .seg_minus  (seg_minus)
);

// File: tb/lcd_static_drv_tb.sv
module lcd_static_drv_tb;
  localparam int ND   = 3;
  localparam int HALF = 400;
  localparam int W    = ND * 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [ND*4-1:0] digits_bcd = '0;
  logic          lead_one = 1'b0;
  logic          negative = 1'b0;
  logic          overrange = 1'b0;
  logic          lamp_test = 1'b0;
  logic          bp;
  logic [W-1:0]  seg_digits;
  logic [1:0]    seg_half;
  logic          seg_minus;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcd_static_drv #(.NUM_DIGITS(ND), .HALF_PERIOD(HALF)) u_dut (
    .clk(clk), .rst(rst), .digits_bcd(digits_bcd), .lead_one(lead_one),
    .negative(negative), .overrange(overrange), .lamp_test(lamp_test),
    .bp(bp), .seg_digits(seg_digits), .seg_half(seg_half), .seg_minus(seg_minus)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] c);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66,
                           7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (c <= 4'd9) ? t[c] : 7'h00;
  endfunction

  function automatic logic [W-1:0] ref_digits(input logic [ND*4-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < ND; i++) r[i*7 +: 7] = ref_seg(b[i*4 +: 4]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Waits at negedges until bp changes; returns clocks waited
  task automatic wait_toggle(output int n);
    logic old;
    old = bp;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (bp === old && n < 3 * HALF);
  endtask

  // Compare outputs against lit pattern at current bp phase
  task automatic check_display(input string req, input logic [W-1:0] dig_on,
                               input logic [1:0] half_on, input logic minus_on);
    chk({req, " digits"}, 32'(seg_digits), 32'(dig_on ^ {W{bp}}));
    chk({req, " half"},   32'(seg_half),   32'(half_on ^ {2{bp}}));
    chk({req, " minus"},  32'(seg_minus),  32'(minus_on ^ bp));
  endtask

  task automatic apply_and_check(input string req, input logic [ND*4-1:0] b,
      input logic lo, input logic ng, input logic ov, input logic lt,
      input logic [W-1:0] exp_dig, input logic [1:0] exp_half, input logic exp_minus);
    int n;
    digits_bcd = b; lead_one = lo; negative = ng; overrange = ov; lamp_test = lt;
    wait_toggle(n);
    check_display(req, exp_dig, exp_half, exp_minus);
  endtask

  task automatic test_reset();
    repeat (5) @(negedge clk);
    chk("R1 bp in reset", 32'(bp), 0);
    chk("R1 segs in reset", 32'({seg_digits, seg_half, seg_minus}), 0);
    rst = 1'b0;
    repeat (HALF - 2) @(negedge clk);
    chk("R1 segs before first toggle", 32'({bp, seg_digits, seg_half, seg_minus}), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R2 first toggle on edge HALF", 32'(bp), 1);
  endtask

  task automatic test_period();
    int n;
    for (int k = 0; k < 3; k++) begin
      wait_toggle(n);
      chk("R2 half period", 32'(n), 32'(HALF));
    end
  endtask

  task automatic test_digits();
    for (int d = 0; d < 10; d++) begin
      logic [ND*4-1:0] b;
      b = {4'(d), 4'((d + 3) % 10), 4'((d + 7) % 10)};
      apply_and_check("R5 decode", b, 0, 0, 0, 0, ref_digits(b), 2'b00, 0);
    end
  endtask

  task automatic test_invalid();
    apply_and_check("R6 codes above 9", {4'hA, 4'hF, 4'h5}, 0, 0, 0, 0,
                    {14'h0, 7'h6D}, 2'b00, 0);
    apply_and_check("R6 codes above 9", {4'hC, 4'hB, 4'hE}, 0, 0, 0, 0, '0, 2'b00, 0);
  endtask

  task automatic test_half_sign();
    logic [ND*4-1:0] b;
    b = 12'h907;
    apply_and_check("R7 lead one", b, 1, 0, 0, 0, ref_digits(b), 2'b11, 0);
    apply_and_check("R8 negative", b, 0, 1, 0, 0, ref_digits(b), 2'b00, 1);
    apply_and_check("R7 R8 both", b, 1, 1, 0, 0, ref_digits(b), 2'b11, 1);
  endtask

  task automatic test_stable_phase();
    logic [W+2:0] snap;
    logic         bsnap;
    apply_and_check("R3 lit antiphase", 12'h123, 1, 1, 0, 0, ref_digits(12'h123), 2'b11, 1);
    snap = {seg_digits, seg_half, seg_minus};
    bsnap = bp;
    repeat (HALF / 2) @(negedge clk);
    chk("R3 no change mid phase", 32'({seg_digits, seg_half, seg_minus}), 32'(snap));
    chk("R3 bp steady mid phase", 32'(bp), 32'(bsnap));
    apply_and_check("R3 next phase", 12'h123, 1, 1, 0, 0, ref_digits(12'h123), 2'b11, 1);
  endtask

  task automatic test_midphase();
    int n;
    logic [W+2:0] snap;
    apply_and_check("R4 setup", 12'h456, 0, 0, 0, 0, ref_digits(12'h456), 2'b00, 0);
    repeat (100) @(negedge clk);
    snap = {seg_digits, seg_half, seg_minus};
    digits_bcd = 12'h888; negative = 1;
    repeat (100) @(negedge clk);
    chk("R4 mid-phase input ignored", 32'({seg_digits, seg_half, seg_minus}), 32'(snap));
    wait_toggle(n);
    check_display("R4 shown at next toggle", ref_digits(12'h888), 2'b00, 1);
  endtask

  task automatic test_overrange();
    apply_and_check("R9 blank", 12'h999, 1, 1, 1, 0, '0, 2'b11, 1);
    apply_and_check("R9 blank plain", 12'h321, 0, 0, 1, 0, '0, 2'b00, 0);
  endtask

  task automatic test_lamp();
    apply_and_check("R10 lamp", 12'h000, 0, 0, 0, 1, '1, 2'b11, 1);
    apply_and_check("R10 lamp over overrange", 12'hFA1, 0, 0, 1, 1, '1, 2'b11, 1);
    apply_and_check("R10 release", 12'h210, 0, 0, 0, 0, ref_digits(12'h210), 2'b00, 0);
  endtask

  initial begin
    test_reset();
    test_period();
    test_digits();
    test_invalid();
    test_half_sign();
    test_stable_phase();
    test_midphase();
    test_overrange();
    test_lamp();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule